// File: doc/BRIEF.md
# Flash Reset and Ready/Busy Controller

This block supervises the reset pin, the ready/busy line and the write-protection check of a byte-wide flash device. The flash array has sixteen equal blocks, and the blocks are protected in pairs. The reset pin level reaches the block already decoded into one of three digital codes: low, normal or high-voltage. The block filters that level so that only a held pulse counts as a hardware reset. It then holds the device busy through a recovery window before the command interface opens again. It also combines the busy and suspend status of the program/erase engine into one open-drain pull-down enable.

A supply-lockout flag closes the command interface at once. If the engine is busy while lockout is high, the block requests an abort. It also requests an abort while a hardware reset is held and the engine is busy.

For every program/erase request, the block reports one cycle later whether the operation is permitted on the target block. It bases that answer on an eight-bit group-protection register. Driving the reset pin to the high-voltage level lifts all protection for as long as the pin stays there.

Top module: `flash_rst_rdy_ctrl`

## Requirements
- R1: After `rst_n` is released with the pin at normal level, the block is ready: `rb_pull`=0, `cmd_en`=1, `abort_req`=0 and `perm_valid`=0.
- R2: A pin-low code (`rst_pin_lvl`=2'b00) sampled on fewer than MIN_RST_CYC consecutive rising edges has no effect: `rb_pull` stays 0 and `cmd_en` stays 1, during the pulse and after it.
- R3: On the MIN_RST_CYC-th consecutive rising edge that samples the pin low, `rb_pull` rises and `cmd_en` falls. Both hold for as long as the pin stays low.
- R4: After a taken reset, the first edge that samples the pin not low starts recovery. `rb_pull` stays 1 and `cmd_en` stays 0 until REC_CYC further edges have passed, and from that edge on the block is ready.
- R5: While ready, `rb_pull` equals `eng_busy & ~eng_suspend`. It is released in erase-suspend and when the engine is idle.
- R6: While `lockout` is 1, `cmd_en` is 0 in the same cycle. `abort_req` is 1 whenever `eng_busy` is 1 together with either `lockout` or a held hardware reset.
- R7: The block index is `req_addr[19:16]` and the protection group is the block index divided by two, which selects bit `grp_prot[group]`. One edge after `req_valid`, `perm_valid` is 1 for one cycle. `perm_ok` is 0 if that group's bit is 1.
- R8: While `rst_pin_lvl`=2'b10 (high voltage), every request sampled with `cmd_en`=1 returns `perm_ok`=1 whatever `grp_prot` holds.
- R9: A request sampled while `cmd_en`=0 returns `perm_ok`=0.
- R10: The code 2'b11 on `rst_pin_lvl` is treated as the normal level: it neither resets nor unprotects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| rst_pin_lvl | input | 2 | Decoded reset pin level: 00 low, 01 normal, 10 high voltage, 11 normal |
| lockout | input | 1 | Supply below the lockout level |
| eng_busy | input | 1 | Program/erase engine running |
| eng_suspend | input | 1 | Engine in erase-suspend |
| grp_prot | input | 8 | Protection bit for each group of two blocks |
| req_valid | input | 1 | Program/erase permission request |
| req_addr | input | 20 | Target byte address of the request |
| rb_pull | output | 1 | Ready/busy open-drain pull-down enable |
| cmd_en | output | 1 | Command interface enabled |
| abort_req | output | 1 | Request to abort the running operation |
| perm_valid | output | 1 | Permission result valid |
| perm_ok | output | 1 | Operation permitted |

## Verification
The bench drives low pulses exactly one edge shorter than the minimum and exactly at the minimum. A filter that is off by one either resets on glitches or misses a legal reset. It counts the cycles of the recovery window on both sides of its end, so a design that leaves too early lets commands in while the line still reads busy. The permission vectors hit both blocks of each protected pair, the top and bottom groups, the high-voltage override, and the reserved pin code. A wrong shift of the block index, a dropped override, or an override decoded from the wrong code would each show as a flipped `perm_ok`. Lockout is checked with the engine running, so a design that misses the abort, or leaves commands open, is reported.

// File: rtl/flash_rr_pkg.sv
package flash_rr_pkg;

  typedef enum logic [1:0] {
    PIN_LOW  = 2'b00,
    PIN_NORM = 2'b01,
    PIN_HV   = 2'b10,
    PIN_RSV  = 2'b11
  } pin_lvl_e;

  typedef enum logic [1:0] {
    ST_READY   = 2'b00,
    ST_HOLD    = 2'b01,
    ST_RECOVER = 2'b10
  } rst_state_e;

  // block index from a byte address
  function automatic logic [3:0] blk_of(input logic [19:0] addr);
    return addr[19:16];
  endfunction

  // protection group: two adjacent blocks share one group
  function automatic logic [2:0] grp_of(input logic [19:0] addr);
    logic [3:0] b;
    b = blk_of(addr);
    return b[3:1];
  endfunction

endpackage

// File: rtl/flash_rst_filter.sv
module flash_rst_filter
  import flash_rr_pkg::*;
#(
  parameter int MIN_RST_CYC = 4,
  parameter int REC_CYC     = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_low,
  output logic rdy,
  output logic hold
);
  localparam int LCW = $clog2(MIN_RST_CYC + 1);
  localparam int RCW = $clog2(REC_CYC + 1);
  localparam logic [LCW-1:0] LOW_LAST = LCW'(MIN_RST_CYC - 1);
  localparam logic [RCW-1:0] REC_LAST = RCW'(REC_CYC - 1);

  rst_state_e      st_q;
  logic [LCW-1:0]  low_cnt;
  logic [RCW-1:0]  rec_cnt;
  logic            low_done;   // event: held low long enough
  logic            rec_done;   // event: recovery window over

  assign low_done = pin_low && (low_cnt == LOW_LAST);
  assign rec_done = (st_q == ST_RECOVER) && !low_done && (rec_cnt == REC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!pin_low) begin
      low_cnt <= '0;
    end else if (low_cnt != LCW'(MIN_RST_CYC)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_READY;
      rec_cnt <= '0;
    end else if (low_done) begin
      st_q    <= ST_HOLD;
      rec_cnt <= '0;
    end else begin
      case (st_q)
        ST_HOLD: if (!pin_low) begin
          st_q    <= ST_RECOVER;
          rec_cnt <= '0;
        end
        ST_RECOVER: if (rec_done) begin
          st_q <= ST_READY;
        end else begin
          rec_cnt <= rec_cnt + 1'b1;
        end
        default: st_q <= ST_READY;
      endcase
    end
  end

  assign rdy  = (st_q == ST_READY);
  assign hold = (st_q == ST_HOLD);

  a_r2_short_pulse_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && pin_low && low_cnt < LOW_LAST) |=> rdy);
  a_r3_reset_taken: assert property (@(posedge clk) disable iff (!rst_n)
    low_done |=> hold);
  a_r4_exit_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOVER && !rdy) ##1 rdy |-> $past(rec_cnt) == REC_LAST);
  a_r4_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !rdy);

endmodule

// File: rtl/flash_prot_check.sv
module flash_prot_check
  import flash_rr_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int N_GRP  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [N_GRP-1:0]  grp_prot,
  input  logic              hv_unprot,
  input  logic              if_open,
  output logic              perm_valid,
  output logic              perm_ok
);
  logic [2:0] grp;
  logic       grp_locked;

  assign grp        = grp_of(req_addr[19:0]);
  assign grp_locked = grp_prot[grp] && !hv_unprot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_valid <= 1'b0;
      perm_ok    <= 1'b0;
    end else begin
      perm_valid <= req_valid;
      perm_ok    <= req_valid && if_open && !grp_locked;
    end
  end

  a_r7_locked_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hv_unprot && grp_prot[grp]) |=> (perm_valid && !perm_ok));
  a_r8_hv_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hv_unprot && if_open) |=> perm_ok);
  a_r9_closed_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !if_open) |=> !perm_ok);
  a_r7_ok_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    perm_ok |-> perm_valid);

endmodule

// File: rtl/flash_rst_rdy_ctrl.sv
module flash_rst_rdy_ctrl
  import flash_rr_pkg::*;
#(
  parameter int MIN_RST_CYC = 4,
  parameter int REC_CYC     = 6,
  parameter int ADDR_W      = 20,
  parameter int N_BLK       = 16,
  localparam int N_GRP      = N_BLK / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rst_pin_lvl,
  input  logic              lockout,
  input  logic              eng_busy,
  input  logic              eng_suspend,
  input  logic [N_GRP-1:0]  grp_prot,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rb_pull,
  output logic              cmd_en,
  output logic              abort_req,
  output logic              perm_valid,
  output logic              perm_ok
);
  logic pin_low, hv_unprot, rdy, hold, eng_active;

  assign pin_low    = (rst_pin_lvl == PIN_LOW);
  assign hv_unprot  = (rst_pin_lvl == PIN_HV);
  assign eng_active = eng_busy && !eng_suspend;

  flash_rst_filter #(.MIN_RST_CYC(MIN_RST_CYC), .REC_CYC(REC_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_low(pin_low), .rdy(rdy), .hold(hold));

  assign rb_pull   = !rdy || eng_active;
  assign cmd_en    = rdy && !lockout;
  assign abort_req = eng_busy && (lockout || hold);

  flash_prot_check #(.ADDR_W(ADDR_W), .N_GRP(N_GRP)) u_prot (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .grp_prot(grp_prot), .hv_unprot(hv_unprot), .if_open(cmd_en),
    .perm_valid(perm_valid), .perm_ok(perm_ok));

  a_r5_open_means_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en |-> (!rb_pull || eng_active));
  a_r6_lockout_closes: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> !cmd_en);
  a_r3_busy_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (rb_pull && !cmd_en));

endmodule

// File: tb/flash_rst_rdy_ctrl_tb.sv
module flash_rst_rdy_ctrl_tb;
  localparam int MIN_RST = 4;
  localparam int REC     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rst_pin_lvl = 2'b01;
  logic lockout = 0, eng_busy = 0, eng_suspend = 0, req_valid = 0;
  logic [7:0] grp_prot = '0;
  logic [19:0] req_addr = '0;
  logic rb_pull, cmd_en, abort_req, perm_valid, perm_ok;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_rst_rdy_ctrl #(.MIN_RST_CYC(MIN_RST), .REC_CYC(REC)) u_dut (
    .clk(clk), .rst_n(rst_n), .rst_pin_lvl(rst_pin_lvl), .lockout(lockout),
    .eng_busy(eng_busy), .eng_suspend(eng_suspend), .grp_prot(grp_prot),
    .req_valid(req_valid), .req_addr(req_addr), .rb_pull(rb_pull),
    .cmd_en(cmd_en), .abort_req(abort_req), .perm_valid(perm_valid),
    .perm_ok(perm_ok));

  // {pin level, protection, address, expected perm_ok}
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {2'b01, 8'h00, 20'h00000, 1'b1},
    {2'b01, 8'h01, 20'h0FFFF, 1'b0},
    {2'b01, 8'h01, 20'h10000, 1'b0},
    {2'b01, 8'h01, 20'h20000, 1'b1},
    {2'b01, 8'h80, 20'hF1234, 1'b0},
    {2'b01, 8'h80, 20'hE0000, 1'b0},
    {2'b01, 8'h80, 20'hD0000, 1'b1},
    {2'b10, 8'hFF, 20'h55555, 1'b1},
    {2'b10, 8'h80, 20'hF0000, 1'b1},
    {2'b01, 8'h7F, 20'hEFFFF, 1'b1},
    {2'b01, 8'h7F, 20'h70000, 1'b0},
    {2'b11, 8'h04, 20'h40000, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic ask(input logic [19:0] a, input logic exp, input string req);
    req_addr  = a;
    req_valid = 1'b1;
    step();
    chk({req, " valid"}, perm_valid, 1'b1);
    chk({req, " ok"}, perm_ok, exp);
    req_valid = 1'b0;
    step();
    chk({req, " one cycle"}, perm_valid, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 rb_pull", rb_pull, 1'b0);
    chk("R1 cmd_en", cmd_en, 1'b1);
    chk("R1 abort", abort_req, 1'b0);
    chk("R1 perm_valid", perm_valid, 1'b0);

    // R7 R8 R10 permission vectors
    for (int i = 0; i < NV; i++) begin
      rst_pin_lvl = VEC[i][30:29];
      grp_prot    = VEC[i][28:21];
      ask(VEC[i][20:1], VEC[i][0], "R7/R8/R10 vector");
    end
    rst_pin_lvl = 2'b01;
    chk("R10 no reset from code 3", cmd_en, 1'b1);

    // R2 short pulse
    rst_pin_lvl = 2'b00;
    for (int k = 0; k < MIN_RST - 1; k++) begin
      step();
      chk("R2 rb during short pulse", rb_pull, 1'b0);
    end
    rst_pin_lvl = 2'b01;
    step();
    chk("R2 rb after short pulse", rb_pull, 1'b0);
    chk("R2 cmd_en after short pulse", cmd_en, 1'b1);

    // R3 long pulse, with R6 abort during hold
    rst_pin_lvl = 2'b00;
    for (int k = 0; k < MIN_RST - 1; k++) step();
    chk("R3 not yet at MIN-1", rb_pull, 1'b0);
    step();
    chk("R3 rb at MIN", rb_pull, 1'b1);
    chk("R3 cmd_en at MIN", cmd_en, 1'b0);
    step(); step();
    chk("R3 held while low", rb_pull, 1'b1);
    eng_busy = 1'b1;
    #1 chk("R6 abort in reset hold", abort_req, 1'b1);
    eng_busy = 1'b0;
    ask(20'h00000, 1'b0, "R9 denied in reset");
    rst_pin_lvl = 2'b01;
    step();   // recovery begins
    for (int k = 0; k < REC - 1; k++) step();
    chk("R4 rb before window end", rb_pull, 1'b1);
    chk("R4 cmd_en before window end", cmd_en, 1'b0);
    step();
    chk("R4 rb after window", rb_pull, 1'b0);
    chk("R4 cmd_en after window", cmd_en, 1'b1);

    // R5 engine busy / suspend
    eng_busy = 1'b1;
    #1 chk("R5 busy pulls", rb_pull, 1'b1);
    eng_suspend = 1'b1;
    #1 chk("R5 suspend releases", rb_pull, 1'b0);
    eng_suspend = 1'b0;
    eng_busy = 1'b0;
    #1 chk("R5 idle releases", rb_pull, 1'b0);

    // R6 lockout
    eng_busy = 1'b1;
    lockout = 1'b1;
    #1 chk("R6 cmd_en off", cmd_en, 1'b0);
    chk("R6 abort", abort_req, 1'b1);
    step();
    eng_busy = 1'b0;
    grp_prot = 8'h00;
    ask(20'h30000, 1'b0, "R9 denied in lockout");
    rst_pin_lvl = 2'b10;
    ask(20'h30000, 1'b0, "R9 hv still denied in lockout");
    rst_pin_lvl = 2'b01;
    lockout = 1'b0;
    #1 chk("R6 cmd_en back", cmd_en, 1'b1);
    chk("R6 abort cleared", abort_req, 1'b0);
    ask(20'h30000, 1'b1, "R7 open again");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule